// File: doc/BRIEF.md
# Serial DAC Input Register with Daisy-Chain Output

This block is the digital receive side of a 10-bit voltage-output converter. A host drives three pins: a serial clock, a serial data line and an active-low select. While the select is low, each rising serial-clock edge moves one data bit into a 16-bit shift register. When the select returns high, the 10-bit code field of that register is copied into a holding register. The holding register drives the parallel `dac_code` output, which feeds the analog stage outside this block.

A word is 16 bits long and is sent most significant bit first. Bits 15 to 12 are don't-care padding, bits 11 to 2 are the code (bit 11 is the code MSB) and bits 1 to 0 are fill bits that the host sends as zeros. The serial output `dout` returns the previous word, bit 15 first. Each bit is launched on a falling serial-clock edge, so a second device wired to `dout` can sample it on the next rising edge.

All three pins are asynchronous to the fast system clock `clk`. Each pin passes through a two-flop synchronizer, and its edges are detected after that. A synchronous active-low reset clears the shift register, the holding register and `dout`, so the output starts at zero scale (code 000h, while 3FFh is full scale).

Top module: `serial_dac_frontend`

## Requirements
- R1: While `rst_n` is low, the next clock edge forces `dac_code` to 000h, `dout` to 0 and the shift register to all zeros.
- R2: Each rising `sclk_in` edge seen while `cs_n_in` is low shifts the shift register left by one place and loads `din_in` into bit 0.
- R3: On a rising `cs_n_in` edge, `dac_code` takes bits 11 to 2 of the shift register. Bits 15 to 12 (padding) and bits 1 to 0 (fill) have no effect on `dac_code`.
- R4: `dac_code` changes on no event other than a rising `cs_n_in` edge. In particular it holds its value during a whole 16-bit word.
- R5: `sclk_in` edges while `cs_n_in` is high do not change the shift register, so a later latch returns the previously shifted word.
- R6: A low pulse on `cs_n_in` with no `sclk_in` edges keeps the shift register unchanged, and its rising edge reloads the same code.
- R7: During a word, the k-th falling `sclk_in` edge (k = 1..16) drives `dout` with bit 16-k of the word held before that word began. After reset, that earlier word is all zeros.
- R8: `dout` changes only on a falling `sclk_in` edge while `cs_n_in` is low (and on reset).
- R9: A change on any input pin acts on the registers at the third rising `clk` edge after it: two synchronizer stages, then one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| din_in | input | 1 | Serial data, sampled on rising serial-clock edges |
| cs_n_in | input | 1 | Active-low select; its rising edge latches the code |
| dout | output | 1 | Daisy-chain output carrying the previous word |
| dac_code | output | 10 | Holding register driving the converter |

## Verification
Every result lands on the third rising system-clock edge after the pin change that causes it. A change on `cs_n_in` updates `dac_code` there, a rising `sclk_in` shifts there, and a falling `sclk_in` moves `dout` there. The bench changes pins on falling clock edges and holds each serial level for four system clocks. It samples on a falling clock edge after that, so each check looks at a settled value. One directed test drives `cs_n_in` high and samples `dac_code` after the second rising edge, where it must still be old, and after the third, where it must be new. That pins the latency to the exact edge.

// File: rtl/sdac_pkg.sv
// Shared constants for the serial DAC input register: word geometry and
// the bit order of the synchronized pin bundle.
package sdac_pkg;
    localparam int FRAME_W = 16;                      // bits per serial word
    localparam int CODE_W  = 10;                      // converter resolution
    localparam int FILL_W  = 2;                       // trailing fill bits
    localparam int PAD_W   = FRAME_W - CODE_W - FILL_W; // leading padding bits

    // Positions of the pins inside the synchronizer bundle
    localparam int PIN_DIN  = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_CSN  = 2;
    localparam int PIN_N    = 3;

    // Idle levels after reset: select high, clock low, data low
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/sdac_sync_edge.sv
// Two-flop synchronizer plus edge detector for a bundle of asynchronous pins.
// Assumes each pin holds a level for at least three system clocks, so that
// no edge is missed. Levels and edge pulses are aligned across the bundle.
module sdac_sync_edge #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_async,
    output logic [WIDTH-1:0] pins_level,
    output logic [WIDTH-1:0] pins_rise,
    output logic [WIDTH-1:0] pins_fall
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        // Resynchronize one pin and keep its previous synced level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
                prev_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= pins_async[b];
                sync_q[b] <= meta_q[b];
                prev_q[b] <= sync_q[b];
            end
        end

        // Edge pulses last one clock
        always_comb begin
            pins_rise[b] = sync_q[b] & ~prev_q[b];
            pins_fall[b] = ~sync_q[b] & prev_q[b];
        end
    end

    assign pins_level = sync_q;
endmodule

// File: rtl/sdac_frame_shifter.sv
// Serial word shift register with daisy-chain output.
// Shifts one bit in, LSB side, per shift strobe. The bit pushed out of the
// MSB waits in a spill flop. The next launch strobe moves it onto dout, so
// a downstream device sees each bit of the previous word, MSB first.
module sdac_frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               launch_en,
    input  logic               ser_bit,
    output logic [FRAME_W-1:0] frame,
    output logic               dout
);
    logic [FRAME_W-1:0] frame_q;
    logic               spill_q;
    logic               dout_q;

    // Shift on rising serial edges and keep the displaced MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            spill_q <= 1'b0;
        end else if (shift_en) begin
            frame_q <= {frame_q[FRAME_W-2:0], ser_bit};
            spill_q <= frame_q[FRAME_W-1];
        end
    end

    // Launch the displaced bit on falling serial edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (launch_en) begin
            dout_q <= spill_q;
        end
    end

    assign frame = frame_q;
    assign dout  = dout_q;
endmodule

// File: rtl/sdac_code_latch.sv
// Converter holding register. On a load strobe it copies the code field,
// CODE_W bits starting at CODE_LSB, out of the shift register.
// Assumes CODE_LSB + CODE_W <= FRAME_W.
module sdac_code_latch #(
    parameter int FRAME_W  = 16,
    parameter int CODE_W   = 10,
    parameter int CODE_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic [CODE_W-1:0]  code
);
    logic [CODE_W-1:0] code_q;

    // Capture the code field when the select is released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= frame[CODE_LSB +: CODE_W];
        end
    end

    assign code = code_q;
endmodule

// File: rtl/serial_dac_frontend.sv
// Device-side input register of a serial 10-bit DAC.
// Synchronizes the select, clock and data pins to clk. Shifts data while
// the select is low, latches the code field when it rises, and launches
// the previous word on dout for daisy chaining.
// Assumes clk runs at least six times faster than the serial clock.
module serial_dac_frontend #(
    parameter int FRAME_W = sdac_pkg::FRAME_W,
    parameter int CODE_W  = sdac_pkg::CODE_W,
    parameter int FILL_W  = sdac_pkg::FILL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              din_in,
    input  logic              cs_n_in,
    output logic              dout,
    output logic [CODE_W-1:0] dac_code
);
    import sdac_pkg::*;

    localparam int CODE_LSB = FILL_W;

    logic [PIN_N-1:0]   pin_lvl;
    logic [PIN_N-1:0]   pin_rise;
    logic [PIN_N-1:0]   pin_fall;
    logic               cs_n_s;
    logic               din_s;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               cs_rise;
    logic               shift_en;
    logic               launch_en;
    logic [FRAME_W-1:0] frame_q;

    sdac_sync_edge #(
        .WIDTH   (PIN_N),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async ({cs_n_in, sclk_in, din_in}),
        .pins_level (pin_lvl),
        .pins_rise  (pin_rise),
        .pins_fall  (pin_fall)
    );

    // Decode synchronized pin events into register strobes
    always_comb begin
        cs_n_s    = pin_lvl[PIN_CSN];
        din_s     = pin_lvl[PIN_DIN];
        sclk_rise = pin_rise[PIN_SCLK];
        sclk_fall = pin_fall[PIN_SCLK];
        cs_rise   = pin_rise[PIN_CSN];
        shift_en  = sclk_rise & ~cs_n_s;
        launch_en = sclk_fall & ~cs_n_s;
    end

    sdac_frame_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .launch_en (launch_en),
        .ser_bit   (din_s),
        .frame     (frame_q),
        .dout      (dout)
    );

    sdac_code_latch #(
        .FRAME_W  (FRAME_W),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cs_rise),
        .frame (frame_q),
        .code  (dac_code)
    );
endmodule

// File: rtl/sdac_checker.sv
// Property checker for serial_dac_frontend, attached by bind. It watches the
// synchronized strobes, the shift register and the outputs.
module sdac_checker #(
    parameter int FRAME_W  = 16,
    parameter int CODE_W   = 10,
    parameter int CODE_LSB = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk_rise,
    input logic               sclk_fall,
    input logic               cs_rise,
    input logic               cs_n_s,
    input logic               din_s,
    input logic [FRAME_W-1:0] frame,
    input logic               dout,
    input logic [CODE_W-1:0]  dac_code
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && dout == 1'b0 && frame == '0))
        else $error("reset did not clear state"); // R1

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !cs_n_s) |=> frame == {$past(frame[FRAME_W-2:0]), $past(din_s)})
        else $error("shift mismatch"); // R2

    AST_LATCH_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> dac_code == $past(frame[CODE_LSB +: CODE_W]))
        else $error("latched wrong field"); // R3

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(dac_code))
        else $error("code moved without select release"); // R4

    AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(frame))
        else $error("shift register moved while deselected"); // R5

    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall && !cs_n_s) |=> $stable(dout))
        else $error("dout moved off a falling edge"); // R8
endmodule

bind serial_dac_frontend sdac_checker #(
    .FRAME_W  (FRAME_W),
    .CODE_W   (CODE_W),
    .CODE_LSB (CODE_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_rise   (cs_rise),
    .cs_n_s    (cs_n_s),
    .din_s     (din_s),
    .frame     (frame_q),
    .dout      (dout),
    .dac_code  (dac_code)
);

// File: tb/tb_serial_dac_frontend.sv
`timescale 1ns/1ps
module tb_serial_dac_frontend;
    localparam int HOLD = 4;   // system clocks per serial level
    localparam int NVEC = 6;

    // Word sent, code expected (code = word bits 11..2)
    localparam logic [15:0] VEC_WORD [NVEC] = '{16'hAFFC, 16'hF003, 16'h0554,
                                                16'h5AA9, 16'h1234, 16'h0000};
    localparam logic [9:0]  VEC_CODE [NVEC] = '{10'h3FF, 10'h000, 10'h155,
                                                10'h2AA, 10'h08D, 10'h000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0;
    logic       din_in = 1'b0;
    logic       cs_n_in = 1'b1;
    logic       dout;
    logic [9:0] dac_code;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [15:0] prev_word = 16'h0000;

    always #2.5 clk = ~clk;

    serial_dac_frontend dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .din_in   (din_in),
        .cs_n_in  (cs_n_in),
        .dout     (dout),
        .dac_code (dac_code)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one word with the select low; optionally release the select
    task automatic send_word(input logic [15:0] w, input bit release_cs,
                             output logic [15:0] seen);
        logic [9:0] code_before;
        code_before = dac_code;
        cs_n_in = 1'b0;
        idle(HOLD);
        for (int i = 15; i >= 0; i--) begin
            din_in = w[i];
            idle(HOLD);
            sclk_in = 1'b1;
            idle(HOLD);
            sclk_in = 1'b0;
            idle(HOLD);
            seen[i] = dout;
        end
        check(dac_code == code_before, "R4 code held during word",
              {6'd0, dac_code}, {6'd0, code_before});
        if (release_cs) begin
            cs_n_in = 1'b1;
            idle(HOLD);
        end
    endtask

    initial begin
        logic [15:0] seen;
        logic [9:0]  held;
        logic        d_before;

        idle(3);
        check(dac_code == 10'h000, "R1 reset code", {6'd0, dac_code}, 16'h0000);
        check(dout == 1'b0, "R1 reset dout", {15'd0, dout}, 16'h0000);
        rst_n = 1'b1;
        idle(HOLD);

        // Table walk: R2 R3 R7
        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC_WORD[v], 1'b1, seen);
            check(dac_code == VEC_CODE[v], "R3 latched code (R2 shift)",
                  {6'd0, dac_code}, {6'd0, VEC_CODE[v]});
            check(seen == prev_word, "R7 daisy-chain previous word", seen, prev_word);
            prev_word = VEC_WORD[v];
        end

        // R9: latency of the latch is three clock edges
        send_word(16'h0FFC, 1'b0, seen);
        @(negedge clk);
        cs_n_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(dac_code == 10'h000, "R9 not yet latched after two edges",
              {6'd0, dac_code}, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        check(dac_code == 10'h3FF, "R9 latched on third edge",
              {6'd0, dac_code}, 16'h03FF);
        idle(HOLD);

        // R5 R8: serial clocks while deselected are ignored
        held = dac_code;
        d_before = dout;
        din_in = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sclk_in = 1'b1;
            idle(HOLD);
            sclk_in = 1'b0;
            idle(HOLD);
        end
        check(dout == d_before, "R8 dout steady while deselected",
              {15'd0, dout}, {15'd0, d_before});
        check(dac_code == held, "R5 code unchanged by deselected clocks",
              {6'd0, dac_code}, {6'd0, held});

        // R6 (and R5): select pulse with no clocks reloads the same code
        cs_n_in = 1'b0;
        idle(HOLD);
        cs_n_in = 1'b1;
        idle(HOLD);
        check(dac_code == 10'h3FF, "R6 R5 reload after bare select pulse",
              {6'd0, dac_code}, 16'h03FF);

        // R1: reset in mid-operation clears code and dout
        send_word(16'hFFFF, 1'b1, seen);
        rst_n = 1'b0;
        idle(2);
        check(dac_code == 10'h000, "R1 reset clears code", {6'd0, dac_code}, 16'h0000);
        check(dout == 1'b0, "R1 reset clears dout", {15'd0, dout}, 16'h0000);
        rst_n = 1'b1;
        idle(HOLD);
        // R1: the shift register was cleared too, so the chained word is zero
        send_word(16'h0008, 1'b1, seen);
        check(seen == 16'h0000, "R1 R7 chained word zero after reset", seen, 16'h0000);
        check(dac_code == 10'h002, "R3 small code", {6'd0, dac_code}, 16'h0002);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule